// File: doc/BRIEF.md
# Strap-Polarity Link and Activity LED Driver

This block drives a single LED pin that also serves as a configuration strap. After reset is released, the pin is left undriven for a fixed hold window. On the last clock of that window the block samples the pin's level, and that level fixes the LED polarity until the next reset. A low strap gives an active-high output. A high strap gives an active-low output.

A one-bit mode field in a control register picks one of two display styles:

- **Steady mode:** the LED simply shows link status.
- **Activity mode:** the LED stays lit on a good link and blinks for a bounded interval after each activity pulse.

With no link, the LED is dark in both modes.

The driver is meant to sit between the link and activity status of a PHY and the pad ring. `led_oe` controls the pad's output buffer, and `led_o` is the level that buffer drives.

Top module: `led_strap_drv`

## Requirements
- R1: `led_oe` is low while reset is asserted and for the first 15 clock edges after reset is released. It goes high after the 16th edge (STRAP_CYCLES = 16) and stays high until the next reset.
- R2: `strap_in` is sampled on the 16th edge after reset release. A sampled 0 makes lit = `led_o` 1 and dark = 0. A sampled 1 inverts both levels. Changes on `strap_in` after that edge have no effect.
- R3: In steady mode, the LED is lit whenever `link_up` is 1, and activity pulses have no effect on it.
- R4: The mode field is bit 5 of the register at address 0x19. A 1 selects steady mode and a 0 selects activity mode. Reset puts the block in steady mode. Writes to other addresses leave the mode unchanged. Bit 6 of the same register has no effect on the LED.
- R5: In activity mode, with a good link and no blink in progress, the LED is steadily lit.
- R6: In activity mode with a good link, an activity pulse sampled on edge e starts a blink. After edge e+k, for k from 0 to 63, the LED is lit exactly when bit 3 of k is 1, so it is dark for the first 8 cycles. From edge e+64 onward it is steadily lit again.
- R7: A pulse that arrives during a blink restarts the 64-cycle interval from that pulse. The toggle phase keeps counting from the first pulse.
- R8: With `link_up` low, the LED is dark in both modes, whether or not activity pulses arrive. Losing link cancels any blink in progress.
- R9: A register write that changes the mode takes effect after the next clock edge and cancels any blink in progress.
- R10: Activity pulses that arrive while `led_oe` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 1 | Level seen on the shared pin, used as the strap |
| link_up | input | 1 | Link good indication |
| act_pulse | input | 1 | One-cycle activity indication |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 16 | Register write data |
| led_o | output | 1 | LED drive level |
| led_oe | output | 1 | LED output enable (low = pin released for strapping) |

## Verification
The bench runs the whole scenario once with each strap level, so every expected level is checked in both polarities. A design that ignored the strap, or sampled it at the wrong time, would show an inverted LED in one of the two runs.

- **Blink timing:** the LED is compared on every cycle of a blink, including the first cycles past its end. An off-by-one in the interval or in the toggle phase shows up as a single wrong sample.
- **Extended blink:** a second pulse arrives mid-blink. A design that restarted the phase, or failed to extend the interval, diverges from the expected pattern.
- **Blink cancellation:** blinks are interrupted by a mode switch and by link loss. A design that kept its blink state would come back dark instead of lit.
- **Ignored inputs:** pulses arrive inside the strap window, and writes go to a neighbouring address and to bit 6. A design that accepted any of them would start an unexpected blink or change mode.

// File: rtl/led_strap_drv.sv
`timescale 1ns/1ps
module led_strap_drv #(
  parameter int          STRAP_CYCLES = 16,
  parameter int          BLINK_LOG2   = 6,
  parameter int          ADDR_W       = 5,
  parameter int          DATA_W       = 16,
  parameter logic [4:0]  CTRL_ADDR    = 5'h19,
  parameter int          MODE_BIT     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_in,
  input  logic              link_up,
  input  logic              act_pulse,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              led_o,
  output logic              led_oe
);
  localparam int SCW = (STRAP_CYCLES > 1) ? $clog2(STRAP_CYCLES) : 1;
  localparam int BW  = BLINK_LOG2 + 1;
  localparam int PW  = BLINK_LOG2 - 2;
  localparam logic [SCW-1:0] S_LAST = SCW'(STRAP_CYCLES - 1);
  localparam logic [BW-1:0]  B_LEN  = BW'(1) << BLINK_LOG2;

  logic [SCW-1:0] strap_cnt;
  logic           ready, strap_q, mode_q;
  logic [BW-1:0]  blink_left;
  logic [PW-1:0]  phase;

  logic wr_hit, mode_chg, blink_on, start_ok, lit;
  logic unused_wdata;

  assign wr_hit   = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign mode_chg = wr_hit && (reg_wdata[MODE_BIT] != mode_q);
  assign blink_on = (blink_left != '0);
  assign start_ok = ready && link_up && !mode_q && act_pulse;
  assign unused_wdata = ^{reg_wdata[DATA_W-1:MODE_BIT+1], reg_wdata[MODE_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_cnt <= '0;
      ready     <= 1'b0;
      strap_q   <= 1'b0;
    end else if (!ready) begin
      if (strap_cnt == S_LAST) begin
        ready   <= 1'b1;
        strap_q <= strap_in;
      end else begin
        strap_cnt <= strap_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= 1'b1;
    else if (wr_hit) mode_q <= reg_wdata[MODE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blink_left <= '0;
      phase      <= '0;
    end else if (mode_chg || !link_up) begin
      blink_left <= '0;
      phase      <= '0;
    end else if (start_ok) begin
      blink_left <= B_LEN;
      phase      <= blink_on ? phase + 1'b1 : '0;
    end else if (blink_on) begin
      blink_left <= blink_left - 1'b1;
      phase      <= phase + 1'b1;
    end
  end

  assign lit    = link_up && (mode_q || !blink_on || phase[PW-1]);
  assign led_oe = ready;
  assign led_o  = ready ? (lit ^ strap_q) : 1'b0;
endmodule

module led_strap_chk #(
  parameter int          STRAP_CYCLES = 16,
  parameter int          ADDR_W       = 5,
  parameter int          DATA_W       = 16,
  parameter logic [4:0]  CTRL_ADDR    = 5'h19,
  parameter int          MODE_BIT     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_in,
  input logic              link_up,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              led_o,
  input logic              led_oe,
  input logic              mode_q,
  input logic              blink_on
);
  logic [15:0] win_cnt;
  logic        cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      cap     <= 1'b0;
    end else begin
      if (win_cnt != 16'hFFFF) win_cnt <= win_cnt + 1'b1;
      if (win_cnt == 16'(STRAP_CYCLES - 1)) cap <= strap_in;
    end
  end

  assert_oe_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt < 16'(STRAP_CYCLES)) |-> !led_oe);
  assert_oe_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt >= 16'(STRAP_CYCLES)) |-> led_oe);
  assert_nolink_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (led_oe && !link_up) |-> (led_o == cap));
  assert_steady_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (led_oe && link_up && mode_q) |-> (led_o == !cap));
  assert_idle_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (led_oe && link_up && !blink_on) |-> (led_o == !cap));
  assert_mode_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(CTRL_ADDR) && reg_wdata[MODE_BIT] != mode_q)
      |=> (!blink_on && mode_q == $past(reg_wdata[MODE_BIT])));
endmodule

bind led_strap_drv led_strap_chk #(
  .STRAP_CYCLES(STRAP_CYCLES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CTRL_ADDR(CTRL_ADDR), .MODE_BIT(MODE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .link_up(link_up),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .led_o(led_o), .led_oe(led_oe), .mode_q(mode_q), .blink_on(blink_on)
);

// File: tb/tb_led_strap_drv.sv
`timescale 1ns/1ps
module tb_led_strap_drv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_in = 1'b0, link_up = 1'b0, act_pulse = 1'b0, reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic led_o, led_oe;
  int nt = 0, nf = 0;
  bit done = 0;
  logic s;

  always #4 clk = ~clk;

  led_strap_drv dut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .link_up(link_up),
    .act_pulse(act_pulse), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .led_o(led_o), .led_oe(led_oe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    nt++;
    if (got !== exp) begin
      nf++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  function automatic logic lvl(input logic l);
    return l ^ s;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse();
    act_pulse = 1'b1;
    tick();
    act_pulse = 1'b0;
  endtask

  function automatic logic blink_exp(input int k, input int stop);
    return (k < stop) ? logic'((k >> 3) & 1) : 1'b1;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      nf++; nt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nt, nf);
      $finish;
    end
  end

  initial begin
    for (int sv = 0; sv < 2; sv++) begin
      s = logic'(sv);
      rst_n = 1'b0; strap_in = s; link_up = 1'b0; act_pulse = 1'b0; reg_we = 1'b0;
      tick(); tick();
      chk(led_oe, 1'b0, "R1", "oe in reset");
      rst_n = 1'b1;
      for (int i = 1; i <= 16; i++) begin
        tick();
        if (i < 16) chk(led_oe, 1'b0, "R1", "oe inside strap window");
        else        chk(led_oe, 1'b1, "R1", "oe after strap window");
      end
      strap_in = ~s;
      chk(led_o, lvl(1'b0), "R2", "dark level with no link");
      tick();
      chk(led_o, lvl(1'b0), "R8", "dark level, strap pin changed after sampling");
      link_up = 1'b1; tick();
      chk(led_o, lvl(1'b1), "R3", "steady lit with link (reset mode)");
      pulse();
      for (int k = 0; k < 12; k++) begin
        chk(led_o, lvl(1'b1), "R3", "steady mode ignores activity");
        tick();
      end
      wr(5'h18, 16'h0000);
      pulse();
      chk(led_o, lvl(1'b1), "R4", "write to other address keeps steady mode");
      wr(5'h19, 16'h0060);
      pulse();
      chk(led_o, lvl(1'b1), "R4", "bit 6 set, still steady mode");
      wr(5'h19, 16'h0040);
      tick(); tick();
      chk(led_o, lvl(1'b1), "R5", "activity mode idle lit");
      for (int k = 0; k < 10; k++) begin
        tick();
        chk(led_o, lvl(1'b1), "R5", "activity mode idle lit hold");
      end
      pulse();
      for (int k = 0; k <= 70; k++) begin
        chk(led_o, lvl(blink_exp(k, 64)), "R6", $sformatf("blink k=%0d", k));
        tick();
      end
      pulse();
      for (int k = 1; k <= 20; k++) tick();
      pulse();
      for (int k = 21; k <= 21 + 70; k++) begin
        chk(led_o, lvl(blink_exp(k, 21 + 64)), "R7", $sformatf("extended blink k=%0d", k));
        tick();
      end
      pulse();
      tick(); tick(); tick();
      wr(5'h19, 16'h0020);
      chk(led_o, lvl(1'b1), "R9", "switch to steady mid blink");
      wr(5'h19, 16'h0000);
      chk(led_o, lvl(1'b1), "R9", "back to activity mode, blink cancelled");
      tick();
      chk(led_o, lvl(1'b1), "R9", "blink stays cancelled");
      pulse();
      tick();
      link_up = 1'b0; tick();
      chk(led_o, lvl(1'b0), "R8", "link lost mid blink");
      pulse();
      chk(led_o, lvl(1'b0), "R8", "activity without link stays dark");
      link_up = 1'b1; tick();
      chk(led_o, lvl(1'b1), "R8", "link back, blink cancelled");

      rst_n = 1'b0; strap_in = s; tick(); rst_n = 1'b1; link_up = 1'b1;
      for (int i = 1; i <= 16; i++) begin
        if (i == 2) begin reg_we = 1'b1; reg_addr = 5'h19; reg_wdata = 16'h0000; end
        if (i == 3) reg_we = 1'b0;
        act_pulse = (i == 10);
        tick();
      end
      act_pulse = 1'b0;
      strap_in = ~s;
      chk(led_o, lvl(1'b1), "R10", "pulse during strap window ignored");
      pulse();
      chk(led_o, lvl(1'b0), "R10", "pulse after window starts blink");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule